// File: doc/BRIEF.md
# Clock-Shared Framed Serial Transmitter

This block turns a parallel data word into a framed serial bit stream. It is meant for links between logic that runs from one common clock, either inside one device or between devices that share a clock source. No baud divider and no oversampling are used: one line bit is driven per clock cycle. Every frame has three parts. First comes a field of low start bits, then the data word with the most significant bit first, then a field of high stop bits. The number of bits in each field is set by its own parameter.

The user raises a start request with the word on the data input. The word is captured on the cycle the request is accepted. Changes to the input after that have no effect on the frame being sent. If the request is still high on the cycle of the final stop bit, the next frame begins on the very next cycle. Holding the request high therefore gives a continuous stream with no idle gap. A busy flag marks every cycle that carries a frame bit. The line rests high when no frame is being sent.

Top module: `serial_frame_tx`

## Requirements
- R1: Reset is synchronous and active low. On the cycle after any clock edge that samples `rst_n` low, `line_out` is 1 and `busy` is 0.
- R2: When `busy` is 0 and `start_req` is 1 at a clock edge, the request is accepted. In the following cycle `busy` is 1 and `line_out` is 0, the first start bit.
- R3: The first N_START cycles of a frame carry line value 0.
- R4: The next N_DATA cycles carry the captured word, most significant bit first. Bit index N_DATA-1 is sent in frame cycle N_START.
- R5: The last N_STOP cycles of a frame carry line value 1.
- R6: For an isolated frame, `busy` is 1 for exactly N_START+N_DATA+N_STOP consecutive cycles and then returns to 0.
- R7: If `start_req` is 1 on the cycle of the final stop bit, the next frame's first start bit follows in the very next cycle. `busy` stays 1 across the boundary.
- R8: A start request seen on any frame cycle other than the final stop bit is ignored. The current frame is unchanged and no extra frame follows.
- R9: The data word is captured at acceptance. Changes to `data_in` during the frame do not alter the bits sent.
- R10: Asserting reset in the middle of a frame drops the frame. The line goes high and `busy` goes low, and the next accepted frame is sent complete.
- R11: Whenever `busy` is 0, `line_out` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the receiver; one line bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Request to begin a frame with the word on `data_in` |
| data_in | input | N_DATA | Word to be framed, sampled on acceptance |
| line_out | output | 1 | Serial line, high when idle |
| busy | output | 1 | High on every cycle that carries a frame bit |

## Verification
Two functions meet on the same clock edge: the end of a frame and the acceptance of the next one. Both happen on the final stop bit cycle when the start request is high. The bench provokes this by holding the request high through a stream of sixteen back-to-back words. During each frame it changes the data input to the next word, so a capture made at the wrong moment shows up as a corrupted frame. Each frame goes through a shift-register receiver model that checks the start field, the stop field and the word. The bench also requires that `busy` never drops and that no idle cycle appears between frames.

// File: rtl/sftx_pkg.sv
package sftx_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_SEND = 1'b1
  } phase_e;

  // Total number of line cycles taken by one frame.
  function automatic int frame_len(input int n_start, input int n_data, input int n_stop);
    return n_start + n_data + n_stop;
  endfunction

  // Width of a counter that indexes every cycle of a frame.
  function automatic int count_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/sftx_bit_counter.sv
module sftx_bit_counter #(
  parameter int FRAME_LEN = 8,
  parameter int CW        = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          busy,
  output logic [CW-1:0] cnt,
  output logic          at_last
);

  localparam logic [CW-1:0] LAST_IDX = CW'(FRAME_LEN - 1);

  assign at_last = busy && (cnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load || at_last) begin
      cnt <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST_IDX); // R6

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !at_last && !load) |=> (cnt == $past(cnt) + 1'b1)); // R6

endmodule

// File: rtl/sftx_ctrl.sv
module sftx_ctrl
  import sftx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic at_last,
  output logic load,
  output logic shift,
  output logic busy
);

  phase_e phase;
  logic   accept;

  // A request is taken while idle, or on the final stop bit to chain frames.
  assign accept = start_req && ((phase == PH_IDLE) || at_last);
  assign load   = accept;
  assign shift  = (phase == PH_SEND) && !accept;
  assign busy   = (phase == PH_SEND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
    end else if (accept) begin
      phase <= PH_SEND;
    end else if (at_last) begin
      phase <= PH_IDLE;
    end
  end

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (at_last && !start_req) |=> !busy); // R6

  AST_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (at_last && start_req) |=> busy); // R7

  AST_MID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !at_last) |=> busy); // R8

  AST_LOAD_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!busy || at_last)); // R8

endmodule

// File: rtl/sftx_shifter.sv
module sftx_shifter #(
  parameter int N_START = 1,
  parameter int N_DATA  = 8,
  parameter int N_STOP  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [N_DATA-1:0] data_in,
  output logic              line_out
);

  localparam int FL = sftx_pkg::frame_len(N_START, N_DATA, N_STOP);

  logic [FL-1:0] shreg;

  // Frame image: low start field on top, word MSB first, high stop field last.
  function automatic logic [FL-1:0] build_frame(input logic [N_DATA-1:0] w);
    return {{N_START{1'b0}}, w, {N_STOP{1'b1}}};
  endfunction

  assign line_out = shreg[FL-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '1;
    end else if (load) begin
      shreg <= build_frame(data_in);
    end else if (shift) begin
      shreg <= {shreg[FL-2:0], 1'b1};
    end
  end

  AST_FIRST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !line_out); // R2

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
  parameter int N_START = 1,
  parameter int N_DATA  = 8,
  parameter int N_STOP  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic [N_DATA-1:0] data_in,
  output logic              line_out,
  output logic              busy
);

  localparam int FL = sftx_pkg::frame_len(N_START, N_DATA, N_STOP);
  localparam int CW = sftx_pkg::count_width(FL);

  // Named internal events for the assertions.
  logic          ev_load;
  logic          ev_shift;
  logic          ev_last;
  logic [CW-1:0] bit_idx;

  sftx_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .at_last   (ev_last),
    .load      (ev_load),
    .shift     (ev_shift),
    .busy      (busy)
  );

  sftx_bit_counter #(
    .FRAME_LEN (FL),
    .CW        (CW)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ev_load),
    .busy    (busy),
    .cnt     (bit_idx),
    .at_last (ev_last)
  );

  sftx_shifter #(
    .N_START (N_START),
    .N_DATA  (N_DATA),
    .N_STOP  (N_STOP)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_load),
    .shift    (ev_shift),
    .data_in  (data_in),
    .line_out (line_out)
  );

  initial begin
    assert (N_START >= 1 && N_DATA >= 1 && N_STOP >= 1);
  end

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line_out); // R11

  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (line_out && !busy)); // R1

  AST_START_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (bit_idx < CW'(N_START))) |-> !line_out); // R3

  AST_STOP_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (bit_idx >= CW'(N_START + N_DATA))) |-> line_out); // R5

endmodule

// File: tb/tb_serial_frame_tx.sv
`timescale 1ns/1ps
module tb_serial_frame_tx;

  localparam int NS = 2;
  localparam int ND = 4;
  localparam int NP = 2;
  localparam int FL = NS + ND + NP;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_req = 1'b0;
  logic [ND-1:0] data_in = '0;
  logic          line_out;
  logic          busy;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  serial_frame_tx #(.N_START(NS), .N_DATA(ND), .N_STOP(NP)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .data_in   (data_in),
    .line_out  (line_out),
    .busy      (busy)
  );

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected line value at frame cycle k, computed from the field rules.
  function automatic logic exp_bit(input logic [ND-1:0] w, input int k);
    if (k < NS) return 1'b0;
    if (k < NS + ND) return w[ND-1-(k-NS)];
    return 1'b1;
  endfunction

  // Receiver model: shift each line bit in, first bit ends up on top.
  task automatic rx_frame(input int pulse_at, input logic [ND-1:0] pulse_data,
                          input logic [ND-1:0] alt_data, input bit keep_start,
                          output logic [FL-1:0] rx, output bit busy_all);
    rx = '0;
    busy_all = 1'b1;
    for (int k = 0; k < FL; k++) begin
      if (k > 0) @(negedge clk);
      rx = {rx[FL-2:0], line_out};
      busy_all = busy_all & busy;
      if (k == 1) data_in = alt_data;
      if (k == FL-1) start_req = keep_start;
      else if (pulse_at >= 0) begin
        start_req = (k == pulse_at);
        if (k == pulse_at) data_in = pulse_data;
      end
    end
  endtask

  task automatic judge(input logic [FL-1:0] rx, input logic [ND-1:0] w);
    logic [FL-1:0] exp;
    for (int k = 0; k < FL; k++) exp[FL-1-k] = exp_bit(w, k);
    check_eq("R3 start field", 32'(rx[FL-1 -: NS]), 32'(0));
    check_eq("R5 stop field", 32'(rx[NP-1:0]), 32'((1 << NP) - 1));
    check_eq("R4 data MSB first", 32'(rx[NP +: ND]), 32'(w));
    check_eq("R9 whole frame", 32'(rx), 32'(exp));
  endtask

  initial begin
    #(20000 * 8);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [FL-1:0] rx;
    bit ba;
    int bad;

    // R1: reset state
    repeat (3) @(negedge clk);
    check_eq("R1 line in reset", 32'(line_out), 32'(1));
    check_eq("R1 busy in reset", 32'(busy), 32'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R11 idle line", 32'(line_out), 32'(1));

    // Isolated frames, every word value
    for (int w = 0; w < (1 << ND); w++) begin
      data_in = ND'(w);
      start_req = 1'b1;
      @(negedge clk);
      check_eq("R2 busy after accept", 32'(busy), 32'(1));
      check_eq("R2 first start bit", 32'(line_out), 32'(0));
      start_req = 1'b0;
      rx_frame(-1, '0, ~ND'(w), 1'b0, rx, ba);
      judge(rx, ND'(w));
      check_eq("R6 busy over frame", 32'(ba), 32'(1));
      @(negedge clk);
      check_eq("R6 busy drops", 32'(busy), 32'(0));
      check_eq("R11 line idle high", 32'(line_out), 32'(1));
    end

    // Back-to-back stream, request held high
    data_in = '0;
    start_req = 1'b1;
    @(negedge clk);
    for (int i = 0; i < (1 << ND); i++) begin
      rx_frame(-1, '0, ND'((i + 1) % (1 << ND)), (i != (1 << ND) - 1), rx, ba);
      judge(rx, ND'(i));
      check_eq("R7 no gap busy", 32'(ba), 32'(1));
      if (i != (1 << ND) - 1) @(negedge clk);
    end
    @(negedge clk);
    check_eq("R6 stream ends", 32'(busy), 32'(0));

    // R8: request pulsed mid-frame is ignored
    data_in = 4'hA;
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    rx_frame(3, 4'h5, 4'hA, 1'b0, rx, ba);
    start_req = 1'b0;
    judge(rx, 4'hA);
    bad = 0;
    for (int c = 0; c < FL + 2; c++) begin
      @(negedge clk);
      if (busy !== 1'b0 || line_out !== 1'b1) bad++;
    end
    check_eq("R8 no extra frame", 32'(bad), 32'(0));

    // R10: reset in mid-frame
    data_in = 4'h3;
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_eq("R10 line high after reset", 32'(line_out), 32'(1));
    check_eq("R10 busy low after reset", 32'(busy), 32'(0));
    @(negedge clk);
    rst_n = 1'b1;
    bad = 0;
    for (int c = 0; c < FL; c++) begin
      @(negedge clk);
      if (busy !== 1'b0 || line_out !== 1'b1) bad++;
    end
    check_eq("R10 frame dropped", 32'(bad), 32'(0));
    data_in = 4'hC;
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    rx_frame(-1, '0, 4'h0, 1'b0, rx, ba);
    judge(rx, 4'hC);
    check_eq("R10 recovery busy", 32'(ba), 32'(1));

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule